// File: doc/BRIEF.md
# Watch-Mode Power Sequencer

This block keeps track of which operating mode a small microcontroller is in: full-speed active, medium-speed active, subactive (slow clock), or watch. When the CPU issues a sleep strobe and both the standby-select and timer-mode-select configuration bits are 1, the block moves to watch. In watch it stops both clock gates and raises a peripheral-halt signal that stops every peripheral except the wake-up timer. Register, RAM and pin contents stay as they were.

Only an interrupt from the wake-up timer or from external line 0 ends watch, and only if the global mask is 0 and that source is enabled. A low reset also ends it. For an interrupt wake-up, the destination is set by two speed bits. A subactive destination is entered at once. An active destination first passes through a settling wait in which the main clock stays gated. The wait length is 8, 16, ... 1024 slow ticks, chosen by a 3-bit field. When the new mode begins, a one-cycle exception-start pulse is raised.

States of the FSM:
- `S_HIGH`, `S_MED`, `S_SUB` are the three running modes.
- `S_WATCH` is watch.
- `S_SETTLE` is the clock-gated wait.

Transitions of the FSM:
- *enter_watch* runs from any running mode to `S_WATCH`.
- *wake_slow* runs from `S_WATCH` to `S_SUB`.
- *wake_fast* runs from `S_WATCH` to `S_SETTLE`.
- *settle_done* runs from `S_SETTLE` to `S_HIGH` or to `S_MED`.
- *reset* runs from any state to `S_HIGH`.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises, the state is `S_HIGH`. Outputs are then `mode_code`=0, `cpu_clk_en`=1, `sub_clk_en`=0, `periph_halt`=0 and `exc_start`=0. Asserting `rst_n` during a settling wait cancels the wait and gives `S_HIGH`, with no `exc_start`.
- R2: In `S_HIGH`, `S_MED` or `S_SUB`, a cycle with `sleep_stb`=1, `stby_sel`=1 and `tmr_sel`=1 gives watch on the next cycle. Watch shows as `mode_code`=3, `periph_halt`=1, `cpu_clk_en`=0 and `sub_clk_en`=0.
- R3: A `sleep_stb` with `stby_sel`=0 or `tmr_sel`=0 leaves `mode_code` unchanged.
- R4: In watch, either of two inputs wakes the block when `irq_mask`=0. One is `tmr_irq` with `tmr_ien`=1. The other is `ext_irq` with `ext_ien`=1.
- R5: In watch, a request is ignored when `irq_mask`=1 or when its own enable is 0. `mode_code` then stays 3.
- R6: A wake-up with `low_spd_on`=0 and `med_spd_on`=0 ends in `mode_code`=0 with `cpu_clk_en`=1.
- R7: A wake-up with `low_spd_on`=0 and `med_spd_on`=1 ends in `mode_code`=1 with `cpu_clk_en`=1.
- R8: A wake-up with `low_spd_on`=1 goes straight to `mode_code`=2 on the next cycle, with `sub_clk_en`=1 and no settling wait. The value of `med_spd_on` does not matter.
- R9: For an active destination, the settling wait lasts 8<<`settle_sel` slow ticks.
  - The wait counts `slow_tick` pulses.
  - During the wait, `mode_code` stays 3 and `cpu_clk_en` stays 0.
  - The new mode begins in the cycle after the last tick.
  - The speed bits are captured at wake-up.
- R10: `exc_start` is high for exactly one cycle: the first cycle of the new mode after an interrupt wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_stb | input | 1 | Sleep strobe from the CPU |
| stby_sel | input | 1 | Standby-select configuration bit |
| tmr_sel | input | 1 | Timer-mode-select configuration bit |
| low_spd_on | input | 1 | Wake to subactive |
| med_spd_on | input | 1 | Wake to medium-speed active |
| settle_sel | input | 3 | Settling-wait select |
| tmr_irq | input | 1 | Wake-up timer interrupt request |
| tmr_ien | input | 1 | Timer interrupt enable |
| ext_irq | input | 1 | External interrupt-0 request |
| ext_ien | input | 1 | External interrupt enable |
| irq_mask | input | 1 | Global interrupt mask |
| slow_tick | input | 1 | Slow-clock tick strobe |
| cpu_clk_en | output | 1 | Main clock gate |
| sub_clk_en | output | 1 | Subclock gate |
| periph_halt | output | 1 | Halt for peripherals other than the wake-up timer |
| exc_start | output | 1 | Exception-start pulse |
| mode_code | output | 2 | 0 high, 1 medium, 2 subactive, 3 watch |

## Verification
The hardest case to reach from the ports is the last tick of the longest settling wait. This needs a full entry into watch, a qualified wake-up, and 1024 separate tick pulses, with the mode checked both before and after the final one. A table-driven loop repeats the complete sequence (enter, wake, count ticks) for each mix of speed bits, wait length and wake source. A directed step then drives reset into the middle of a wait, to show that the wait is cancelled and that no exception pulse follows.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
    typedef enum logic [1:0] {
        MODE_HIGH  = 2'd0,
        MODE_MED   = 2'd1,
        MODE_SUB   = 2'd2,
        MODE_WATCH = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        S_HIGH   = 3'd0,
        S_MED    = 3'd1,
        S_SUB    = 3'd2,
        S_WATCH  = 3'd3,
        S_SETTLE = 3'd4
    } state_e;
endpackage

// File: rtl/wake_qual.sv
module wake_qual #(
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] ena,
    input  logic            mask,
    output logic            wake
);
    logic [NSRC-1:0] gated;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            assign gated[g] = req[g] & ena[g];
        end
    endgenerate

    assign wake = !mask && (|gated);
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = tick && (cnt == CNT_W'(1));

    assert_load_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt != '0);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int SEL_W      = 3,
    parameter int BASE_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_stb,
    input  logic             stby_sel,
    input  logic             tmr_sel,
    input  logic             low_spd_on,
    input  logic             med_spd_on,
    input  logic [SEL_W-1:0] settle_sel,
    input  logic             tmr_irq,
    input  logic             tmr_ien,
    input  logic             ext_irq,
    input  logic             ext_ien,
    input  logic             irq_mask,
    input  logic             slow_tick,
    output logic             cpu_clk_en,
    output logic             sub_clk_en,
    output logic             periph_halt,
    output logic             exc_start,
    output logic [1:0]       mode_code
);
    localparam int CNT_W = BASE_SHIFT + (1 << SEL_W);

    state_e           state, nxt;
    logic             dest_med;
    logic             wake, settle_done, enter_watch, load;
    logic             exc_next;
    logic [CNT_W-1:0] load_val;

    wake_qual #(.NSRC(2)) u_wake (
        .req  ({ext_irq, tmr_irq}),
        .ena  ({ext_ien, tmr_ien}),
        .mask (irq_mask),
        .wake (wake)
    );

    assign load     = (state == S_WATCH) && wake && !low_spd_on;
    assign load_val = CNT_W'(1) << (CNT_W'(settle_sel) + CNT_W'(BASE_SHIFT));

    settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .tick     (slow_tick),
        .done     (settle_done)
    );

    assign enter_watch = sleep_stb && stby_sel && tmr_sel;

    always_comb begin
        nxt      = state;
        exc_next = 1'b0;
        unique case (state)
            S_HIGH, S_MED, S_SUB: begin
                if (enter_watch) nxt = S_WATCH;
            end
            S_WATCH: begin
                if (wake) begin
                    nxt      = low_spd_on ? S_SUB : S_SETTLE;
                    exc_next = low_spd_on;
                end
            end
            S_SETTLE: begin
                if (settle_done) begin
                    nxt      = dest_med ? S_MED : S_HIGH;
                    exc_next = 1'b1;
                end
            end
            default: nxt = S_HIGH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_HIGH;
            dest_med  <= 1'b0;
            exc_start <= 1'b0;
        end else begin
            state     <= nxt;
            exc_start <= exc_next;
            if (load) dest_med <= med_spd_on;
        end
    end

    always_comb begin
        cpu_clk_en  = 1'b0;
        sub_clk_en  = 1'b0;
        periph_halt = 1'b0;
        mode_code   = MODE_WATCH;
        unique case (state)
            S_HIGH:   begin cpu_clk_en = 1'b1; mode_code = MODE_HIGH; end
            S_MED:    begin cpu_clk_en = 1'b1; mode_code = MODE_MED;  end
            S_SUB:    begin sub_clk_en = 1'b1; mode_code = MODE_SUB;  end
            S_WATCH,
            S_SETTLE: begin periph_halt = 1'b1; mode_code = MODE_WATCH; end
            default:  mode_code = MODE_WATCH;
        endcase
    end

    assert_enter_watch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code != 2'd3 && sleep_stb && stby_sel && tmr_sel) |=> mode_code == 2'd3);

    assert_plain_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code != 2'd3 && sleep_stb && !stby_sel) |=> $stable(mode_code));

    assert_masked_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WATCH && irq_mask) |=> mode_code == 2'd3);

    assert_slow_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WATCH && wake && low_spd_on) |=> (mode_code == 2'd2 && exc_start));

    assert_clk_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> exc_start);

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start |=> !exc_start);
endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_stb = 0, stby_sel = 0, tmr_sel = 0;
    logic       low_spd_on = 0, med_spd_on = 0;
    logic [2:0] settle_sel = 0;
    logic       tmr_irq = 0, tmr_ien = 0, ext_irq = 0, ext_ien = 0;
    logic       irq_mask = 0, slow_tick = 0;
    logic       cpu_clk_en, sub_clk_en, periph_halt, exc_start;
    logic [1:0] mode_code;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_seq i_pwr_mode_seq (
        .clk(clk), .rst_n(rst_n), .sleep_stb(sleep_stb), .stby_sel(stby_sel),
        .tmr_sel(tmr_sel), .low_spd_on(low_spd_on), .med_spd_on(med_spd_on),
        .settle_sel(settle_sel), .tmr_irq(tmr_irq), .tmr_ien(tmr_ien),
        .ext_irq(ext_irq), .ext_ien(ext_ien), .irq_mask(irq_mask),
        .slow_tick(slow_tick), .cpu_clk_en(cpu_clk_en), .sub_clk_en(sub_clk_en),
        .periph_halt(periph_halt), .exc_start(exc_start), .mode_code(mode_code)
    );

    // vector: [7] low, [6] med, [5:3] settle_sel, [2] use ext source, [1:0] expected mode
    localparam logic [7:0] VEC [6] = '{
        {1'b0, 1'b0, 3'd0, 1'b0, 2'd0},
        {1'b0, 1'b1, 3'd1, 1'b1, 2'd1},
        {1'b1, 1'b0, 3'd2, 1'b0, 2'd2},
        {1'b1, 1'b1, 3'd7, 1'b1, 2'd2},
        {1'b0, 1'b0, 3'd7, 1'b0, 2'd0},
        {1'b0, 1'b1, 3'd3, 1'b0, 2'd1}
    };

    task automatic chk(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic enter_watch;
        sleep_stb = 1; stby_sel = 1; tmr_sel = 1;
        step();
        sleep_stb = 0;
        chk("R2 mode", mode_code, 3);
        chk("R2 halt", periph_halt, 1);
        chk("R2 clocks", {cpu_clk_en, sub_clk_en}, 0);
    endtask

    task automatic run_vec(input logic [7:0] v);
        int n;
        low_spd_on = v[7]; med_spd_on = v[6]; settle_sel = v[5:3];
        irq_mask = 0; tmr_ien = 1; ext_ien = 1;
        if (v[2]) ext_irq = 1; else tmr_irq = 1;
        step();
        tmr_irq = 0; ext_irq = 0;
        low_spd_on = ~v[7]; med_spd_on = ~v[6];   // captured at wake, later values must not matter
        if (v[7]) begin
            chk("R8 sub mode", mode_code, 2);
            chk("R8 sub clock", sub_clk_en, 1);
            chk("R10 pulse", exc_start, 1);
        end else begin
            chk("R9 waiting mode", mode_code, 3);
            chk("R9 clock gated", cpu_clk_en, 0);
            n = 8 << v[5:3];
            for (int i = 0; i < n; i++) begin
                slow_tick = 1;
                step();
                slow_tick = 0;
                if (i == n - 2) begin
                    chk("R9 before last tick", mode_code, 3);
                    chk("R9 gated before last", cpu_clk_en, 0);
                end
            end
            chk(v[1:0] == 2'd0 ? "R6 dest" : "R7 dest", mode_code, v[1:0]);
            chk("R9 clock on", cpu_clk_en, 1);
            chk("R10 pulse", exc_start, 1);
        end
        step();
        chk("R10 pulse ends", exc_start, 0);
        low_spd_on = 0; med_spd_on = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk("R1 reset mode", mode_code, 0);
        do_reset();
        chk("R1 mode", mode_code, 0);
        chk("R1 cpu clk", cpu_clk_en, 1);
        chk("R1 outputs", {sub_clk_en, periph_halt, exc_start}, 0);

        foreach (VEC[k]) begin
            enter_watch();
            run_vec(VEC[k]);
        end

        // R2 entry from subactive (last vector left medium; go via subactive)
        enter_watch();
        low_spd_on = 1; tmr_ien = 1; tmr_irq = 1;
        step();
        tmr_irq = 0; low_spd_on = 0;
        chk("R8 sub again", mode_code, 2);
        enter_watch();

        // R3 plain sleep and standby-without-timer do not enter watch
        do_reset();
        sleep_stb = 1; stby_sel = 0; tmr_sel = 1;
        step();
        chk("R3 stby_sel=0", mode_code, 0);
        stby_sel = 1; tmr_sel = 0;
        step();
        sleep_stb = 0;
        chk("R3 tmr_sel=0", mode_code, 0);

        // R5 blocked wake-ups
        enter_watch();
        irq_mask = 1; tmr_ien = 1; tmr_irq = 1; ext_ien = 1; ext_irq = 1;
        step();
        chk("R5 masked", mode_code, 3);
        irq_mask = 0; tmr_ien = 0; ext_ien = 0;
        step();
        chk("R5 disabled", mode_code, 3);
        tmr_irq = 0; ext_irq = 0;

        // R4 external source alone wakes
        ext_ien = 1; ext_irq = 1; low_spd_on = 1;
        step();
        ext_irq = 0; low_spd_on = 0;
        chk("R4 ext wake", mode_code, 2);

        // R1 reset during settling
        enter_watch();
        settle_sel = 3'd2; tmr_ien = 1; tmr_irq = 1;
        step();
        tmr_irq = 0;
        for (int i = 0; i < 5; i++) begin
            slow_tick = 1; step(); slow_tick = 0;
        end
        chk("R9 mid wait", mode_code, 3);
        rst_n = 0;
        #1;
        chk("R1 async reset", mode_code, 0);
        step();
        rst_n = 1;
        step();
        chk("R1 after cancel mode", mode_code, 0);
        chk("R1 no pulse", exc_start, 0);
        for (int i = 0; i < 40; i++) begin
            slow_tick = 1; step(); slow_tick = 0;
        end
        chk("R1 wait cancelled", {mode_code, exc_start}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule